// File: doc/BRIEF.md
# Register-Bank Read Allocator with Rotating Diagonal Priority

This block decides, every clock, which operand-collector unit each register-file bank serves. A request matrix arrives with one row per bank and one column per collector unit. Bit `b*NUM_COLL + c` of `reqMatrix` means that bank `b` holds a read for collector `c`. The allocator scans this matrix along wrapped diagonals, starting from a priority diagonal. It returns, for each bank, the index of the collector it serves and a valid bit.

A bank serves at most one collector per pass. A collector is never blocked by an earlier grant, so it may receive data from several banks in the same pass. To model a register file with extra port throughput, the scan runs `PASSES` times per clock. Each later pass starts one diagonal further on and ignores the bank/collector pairs already granted in that clock. The priority register advances only on cycles where `reqValid` is high. Queueing of the reads and the register storage lie outside the block.

Top module: `wavefront_bank_alloc`

## Requirements
- R1: A grant from bank b to collector c is only ever reported when bit `b*NUM_COLL + c` of `reqMatrix` is 1 and `reqValid` is 1.
- R2: In each pass, a bank reports at most one grant, with its `grantValid` bit. That bit is 1 exactly when the bank's row, after the exclusions of R5, has at least one bit set.
- R3: In pass 0 with priority P, bank b is granted the first requested collector in the order (P+b) mod N, (P+b+1) mod N, and so on, where N is `NUM_COLL`.
- R4: Grants to one collector never block one another: several banks may be granted the same collector in the same pass.
- R5: Pass k uses priority (P+k) mod N. It ignores every bank/collector pair already granted by passes 0..k-1 in the same cycle.
- R6: After reset, `curPriority` is 0.
- R7: On a clock edge where `reqValid` is 1, `curPriority` becomes (P+PASSES) mod N. On an edge where `reqValid` is 0, it holds its value.
- R8: While `reqValid` is 0, every `grantValid` bit is 0.
- R9: Grant layout: pass k, bank b uses `grantValid[k*NUM_BANKS+b]` and `grantIdx[(k*NUM_BANKS+b)*IW +: IW]`, where IW = clog2(N).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request matrix is valid this cycle |
| reqMatrix | input | NUM_BANKS*NUM_COLL | Request bits, row per bank |
| grantIdx | output | PASSES*NUM_BANKS*IW | Granted collector index per pass and bank |
| grantValid | output | PASSES*NUM_BANKS | Grant present per pass and bank |
| curPriority | output | IW | Current priority diagonal |

## Verification
Two things happen in the same cycle: the combinational grant scan uses the current priority, and the priority register steps by `PASSES` at the edge that closes that cycle. The bench drives a request pattern at the falling edge and compares every pass's grants against a diagonal-scan model before the rising edge. It then checks the new priority after the edge, so a grant computed from a priority that was already updated shows up as a mismatch. Requests concentrated on one collector exercise the multiple-grant rule and the exclusion across passes in the same cycle.

// File: rtl/wba_pkg.sv
package wba_pkg;
  typedef struct packed {
    logic active;   // grants enabled this cycle
    logic advance;  // priority steps at the coming edge
  } wbaStrobe_t;
endpackage

// File: rtl/wba_ctrl.sv
module wba_ctrl
  import wba_pkg::*;
#(
  parameter int NUM_COLL = 8,
  parameter int PASSES   = 2,
  localparam int IW      = $clog2(NUM_COLL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reqValid,
  output wbaStrobe_t    strobes,
  output logic [IW-1:0] priority_q
);
  localparam int STEP = PASSES % NUM_COLL;

  logic [IW:0] sumPri;
  logic [IW-1:0] nextPri;

  always_comb begin
    strobes.active  = reqValid;
    strobes.advance = reqValid;
    sumPri  = {1'b0, priority_q} + (IW+1)'(STEP);
    nextPri = (sumPri >= (IW+1)'(NUM_COLL)) ? IW'(sumPri - (IW+1)'(NUM_COLL))
                                            : IW'(sumPri);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               priority_q <= '0;
    else if (strobes.advance) priority_q <= nextPri;
  end
endmodule

// File: rtl/wba_pass.sv
module wba_pass #(
  parameter int NUM_BANKS = 4,
  parameter int NUM_COLL  = 8,
  localparam int IW       = $clog2(NUM_COLL)
) (
  input  logic [NUM_BANKS*NUM_COLL-1:0] reqIn,
  input  logic [IW-1:0]                 passPri,
  output logic [NUM_BANKS*IW-1:0]       idxOut,
  output logic [NUM_BANKS-1:0]          vldOut,
  output logic [NUM_BANKS*NUM_COLL-1:0] remOut
);
  always_comb begin
    idxOut = '0;
    vldOut = '0;
    remOut = reqIn;
    for (int b = 0; b < NUM_BANKS; b++) begin
      for (int p = 0; p < NUM_COLL; p++) begin
        int c;
        c = (int'(passPri) + b + p) % NUM_COLL;
        if (!vldOut[b] && reqIn[b*NUM_COLL + c]) begin
          vldOut[b] = 1'b1;
          idxOut[b*IW +: IW] = IW'(c);
          remOut[b*NUM_COLL + c] = 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/wba_datapath.sv
module wba_datapath
  import wba_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int NUM_COLL  = 8,
  parameter int PASSES    = 2,
  localparam int IW       = $clog2(NUM_COLL),
  localparam int MW       = NUM_BANKS*NUM_COLL
) (
  input  wbaStrobe_t                     strobes,
  input  logic [IW-1:0]                  basePri,
  input  logic [MW-1:0]                  reqMatrix,
  output logic [PASSES*NUM_BANKS*IW-1:0] grantIdx,
  output logic [PASSES*NUM_BANKS-1:0]    grantValid
);
  logic [(PASSES+1)*MW-1:0] remChain;

  assign remChain[MW-1:0] = strobes.active ? reqMatrix : '0;

  for (genvar k = 0; k < PASSES; k++) begin : g_pass
    logic [IW-1:0] passPri;
    assign passPri = IW'((int'(basePri) + k) % NUM_COLL);

    wba_pass #(.NUM_BANKS(NUM_BANKS), .NUM_COLL(NUM_COLL)) u_pass (
      .reqIn  (remChain[k*MW +: MW]),
      .passPri(passPri),
      .idxOut (grantIdx[k*NUM_BANKS*IW +: NUM_BANKS*IW]),
      .vldOut (grantValid[k*NUM_BANKS +: NUM_BANKS]),
      .remOut (remChain[(k+1)*MW +: MW])
    );
  end
endmodule

// File: rtl/wavefront_bank_alloc.sv
module wavefront_bank_alloc
  import wba_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int NUM_COLL  = 8,
  parameter int PASSES    = 2,
  localparam int IW       = $clog2(NUM_COLL)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           reqValid,
  input  logic [NUM_BANKS*NUM_COLL-1:0]  reqMatrix,
  output logic [PASSES*NUM_BANKS*IW-1:0] grantIdx,
  output logic [PASSES*NUM_BANKS-1:0]    grantValid,
  output logic [IW-1:0]                  curPriority
);
  wbaStrobe_t strobes;

  wba_ctrl #(.NUM_COLL(NUM_COLL), .PASSES(PASSES)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .reqValid  (reqValid),
    .strobes   (strobes),
    .priority_q(curPriority)
  );

  wba_datapath #(.NUM_BANKS(NUM_BANKS), .NUM_COLL(NUM_COLL), .PASSES(PASSES)) u_dp (
    .strobes   (strobes),
    .basePri   (curPriority),
    .reqMatrix (reqMatrix),
    .grantIdx  (grantIdx),
    .grantValid(grantValid)
  );
endmodule

// File: rtl/wba_checker.sv
module wba_checker #(
  parameter int NUM_BANKS = 4,
  parameter int NUM_COLL  = 8,
  parameter int PASSES    = 2,
  localparam int IW       = $clog2(NUM_COLL)
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           reqValid,
  input logic [NUM_BANKS*NUM_COLL-1:0]  reqMatrix,
  input logic [PASSES*NUM_BANKS*IW-1:0] grantIdx,
  input logic [PASSES*NUM_BANKS-1:0]    grantValid,
  input logic [IW-1:0]                  curPriority
);
  // R6: priority is zero in the first cycle out of reset
  a_r6_reset_priority: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> curPriority == '0);

  // R7: step by PASSES when valid
  a_r7_priority_step: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> int'(curPriority) == (int'($past(curPriority)) + PASSES) % NUM_COLL);

  // R7: hold when idle
  a_r7_priority_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> $stable(curPriority));

  // R8: no grants while idle
  a_r8_idle_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |-> grantValid == '0);

  for (genvar k = 0; k < PASSES; k++) begin : g_k
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_b
      localparam int SLOT = k*NUM_BANKS + b;
      // R1: each grant backed by a request bit
      a_r1_grant_requested: assert property (@(posedge clk) disable iff (!rst_n)
        grantValid[SLOT] |-> reqMatrix[b*NUM_COLL + int'(grantIdx[SLOT*IW +: IW])]);
      if (k > 0) begin : g_later
        // R5: a later pass never repeats the pair granted by pass 0
        a_r5_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
          (grantValid[SLOT] && grantValid[b])
            |-> grantIdx[SLOT*IW +: IW] != grantIdx[b*IW +: IW]);
      end
    end
  end
endmodule

bind wavefront_bank_alloc wba_checker #(
  .NUM_BANKS(NUM_BANKS), .NUM_COLL(NUM_COLL), .PASSES(PASSES)
) u_wba_checker (.*);

// File: tb/wavefront_bank_alloc_bench.sv
module wavefront_bank_alloc_bench;
  localparam int NB = 4;
  localparam int NC = 8;
  localparam int NP = 2;
  localparam int IW = 3;
  localparam int SQ = (NB > NC) ? NB : NC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reqValid = 1'b0;
  logic [NB*NC-1:0] reqMatrix = '0;
  logic [NP*NB*IW-1:0] grantIdx;
  logic [NP*NB-1:0] grantValid;
  logic [IW-1:0] curPriority;

  int nChecks = 0;
  int nFails = 0;
  int expPri = 0;
  int expIdx [NP][NB];
  bit expVld [NP][NB];

  always #2.5 clk = ~clk;

  wavefront_bank_alloc #(.NUM_BANKS(NB), .NUM_COLL(NC), .PASSES(NP)) u_wavefront_bank_alloc (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqMatrix(reqMatrix),
    .grantIdx(grantIdx), .grantValid(grantValid), .curPriority(curPriority)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Diagonal scan model built from R2, R3, R5, R8
  task automatic model(input int pri, input bit vld, input logic [NB*NC-1:0] req);
    logic [NB*NC-1:0] rem;
    rem = vld ? req : '0;
    for (int k = 0; k < NP; k++) begin
      int prio;
      prio = (pri + k) % NC;
      for (int b = 0; b < NB; b++) begin expVld[k][b] = 0; expIdx[k][b] = 0; end
      for (int p = 0; p < SQ; p++) begin
        int o;
        o = (prio + p) % NC;
        for (int i = 0; i < NB; i++) begin
          if (!expVld[k][i] && rem[i*NC + o]) begin
            expVld[k][i] = 1;
            expIdx[k][i] = o;
          end
          o = (o + 1) % NC;
        end
      end
      for (int b = 0; b < NB; b++)
        if (expVld[k][b]) rem[b*NC + expIdx[k][b]] = 1'b0;
    end
  endtask

  // drive at negedge, check grants before the edge, priority after it
  task automatic apply(input string tag, input bit vld, input logic [NB*NC-1:0] req);
    @(negedge clk);
    reqValid = vld;
    reqMatrix = req;
    #1;
    model(expPri, vld, req);
    chk({tag, " R3 priority in use"}, int'(curPriority), expPri);
    for (int k = 0; k < NP; k++)
      for (int b = 0; b < NB; b++) begin
        int s;
        s = k*NB + b;
        chk({tag, " R2/R9 grantValid"}, int'(grantValid[s]), int'(expVld[k][b]));
        if (expVld[k][b])
          chk({tag, " R3/R5 grantIdx"}, int'(grantIdx[s*IW +: IW]), expIdx[k][b]);
      end
    @(posedge clk);
    if (vld) expPri = (expPri + NP) % NC;
    #1;
    chk({tag, " R7 priority update"}, int'(curPriority), expPri);
  endtask

  task automatic t_reset;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    expPri = 0;
    chk("R6 reset priority", int'(curPriority), 0);
    chk("R8 reset no grants", int'(grantValid), 0);
  endtask

  task automatic t_idle;
    logic [NB*NC-1:0] all;
    all = '1;
    apply("R8 idle", 1'b0, all);
    chk("R8 idle grants", int'(grantValid), 0);
    apply("R7 idle hold", 1'b0, 32'h0000_0F00);
  endtask

  task automatic t_single;
    // bank 2 requests collector 6 only (bit 2*8+6)
    apply("R1 single", 1'b1, 32'h0040_0000);
  endtask

  task automatic t_full;
    logic [NB*NC-1:0] all;
    all = '1;
    apply("R3 full", 1'b1, all);
    apply("R3 full rotated", 1'b1, all);
  endtask

  task automatic t_shared_collector;
    logic [NB*NC-1:0] m;
    m = '0;
    for (int b = 0; b < NB; b++) m[b*NC + 5] = 1'b1;
    apply("R4 shared collector", 1'b1, m);
    // pass 0 grants every bank to collector 5, pass 1 then has nothing
    chk("R4 all banks pass0", int'(grantValid[NB-1:0]), 32'hF);
    chk("R5 pass1 empty", int'(grantValid[2*NB-1:NB]), 0);
  endtask

  task automatic t_two_per_row;
    logic [NB*NC-1:0] m;
    m = '0;
    for (int b = 0; b < NB; b++) begin
      m[b*NC + 1] = 1'b1;
      m[b*NC + 7] = 1'b1;
    end
    apply("R5 two per row", 1'b1, m);
  endtask

  task automatic t_random;
    for (int n = 0; n < 60; n++) begin
      logic [NB*NC-1:0] m;
      m = $urandom() & $urandom();
      apply("R2 random", ($urandom() % 5) != 0, m);
    end
  endtask

  initial begin
    for (int w = 0; w < 20000; w++) @(posedge clk);
    nFails++;
    nChecks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    t_reset();
    t_idle();
    t_single();
    t_full();
    t_shared_collector();
    t_two_per_row();
    t_random();
    t_idle();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule